// File: doc/BRIEF.md
# Queue Parameter Cache with Admission

This block serves the enqueue side of a queue manager. Each request names one of up to 2^20 queues and carries a buffer handle and a frame length. Per-queue state is held in a small fully associative cache of 16 lines. Each line holds the queue length, the discard threshold, the weight quantum, and the head, tail and count of the queue descriptor.

On a hit, the cached line is used at once. On a miss, the least recently used line is written back to a backing memory port if it is occupied, and the new queue's line is then read in. A threshold test then either admits the frame or drops it. When a frame is admitted, the block emits an enqueue indication, writes the new queue length back to memory, and, if the queue was empty, asks the scheduler to add the queue with its quantum as credit.

Requests are taken in rounds of at most five. A one-cycle sync state closes each round. A probe port lets a concurrent dequeue path see whether a queue is cached, or is still being loaded and must not be fetched again.

The control is a single state machine with these states:
- `ST_IDLE` accepts a request, or goes to `ST_SYNC` when a partial round meets an empty input.
- `ST_LOOKUP` goes to `ST_ADMIT` on a hit, to `ST_FILL_REQ` on a miss with a free line, and to `ST_EVICT` on a miss with all lines occupied.
- `ST_EVICT` goes to `ST_FILL_REQ` once the write-back is accepted.
- `ST_FILL_REQ` goes to `ST_FILL_WAIT` once the read is accepted.
- `ST_FILL_WAIT` goes to `ST_ADMIT` on the response.
- `ST_ADMIT` goes to `ST_WRLEN` when the frame is admitted. On a drop it goes to `ST_SYNC` if the round is full, otherwise to `ST_IDLE`.
- `ST_WRLEN` goes to `ST_SYNC` or `ST_IDLE` once the length write is accepted, by the same round test.
- `ST_SYNC` always returns to `ST_IDLE`.

Top module: `qparam_cache`

## Requirements
- R1: After reset, or after `clear` is high for one clock, every cache line is empty: the probe reports neither cached nor loading for any queue, the next request to any queue misses without a write-back, and `req_ready` is high in idle.
- R2: A request to a cached queue causes no memory traffic, and its outcome (`drop_valid` or `enq_valid`) is visible in the second cycle after the accepting edge.
- R3: A request to an uncached queue issues exactly one memory request with `mem_req_op` = 0 (read) and `mem_req_addr` = the queue id. `req_ready` stays low from acceptance until the outcome cycle.
- R4: A miss with all 16 lines occupied first writes back the least recently used line (`mem_req_op` = 1, whole line, `mem_req_addr` = its queue id), then reads the new line. Both hits and fills make a line the most recently used.
- R5: If the queue length plus the frame length exceeds the discard threshold, `drop_valid` pulses with the request's handle. The queue length is left unchanged and no length write follows.
- R6: Otherwise `enq_valid` pulses with the queue id and handle, and the cached queue length grows by the frame length. `drop_valid` and `enq_valid` are never high together.
- R7: When an admitted frame finds a queue length of zero, `sched_valid` pulses in the same cycle as `enq_valid`, carrying the queue id and, as credit, the line's weight quantum.
- R8: In the cycle after every admit, a memory request with `mem_req_op` = 2 (length write) carries the queue id and the new queue length in the length field.
- R9: While a fill is outstanding, the probe reports the queue as loading and not cached. Once the fill completes, the probe reports it as cached.
- R10: At most five requests are accepted per round. `batch_end` pulses for one cycle after the fifth request completes, or when the block is idle with a partial round and no request waiting. `req_ready` is low during that cycle.
- R11: A written-back line carries the current cached queue length.

Memory lines are 144 bits wide, packed from the top bit down:
- bits [143:120]: queue length (24 bits)
- bits [119:96]: discard threshold (24 bits)
- bits [95:80]: weight quantum (16 bits)
- bits [79:48]: head (32 bits)
- bits [47:16]: tail (32 bits)
- bits [15:0]: count (16 bits)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous invalidate of all lines; returns to idle |
| req_valid | input | 1 | Enqueue request present |
| req_ready | output | 1 | Request accepted at this edge when both high |
| req_qid | input | 20 | Queue id |
| req_handle | input | 32 | Buffer handle |
| req_len | input | 16 | Frame length in bytes |
| mem_req_valid | output | 1 | Backing memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_op | output | 2 | 0 read line, 1 write line, 2 write length |
| mem_req_addr | output | 20 | Queue id of the line |
| mem_req_wdata | output | 144 | Line data for writes |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 144 | Returned line |
| drop_valid | output | 1 | Frame discarded |
| drop_handle | output | 32 | Handle of the discarded frame |
| enq_valid | output | 1 | Frame admitted |
| enq_qid | output | 20 | Queue of the admitted frame |
| enq_handle | output | 32 | Handle of the admitted frame |
| sched_valid | output | 1 | Queue newly active, add to schedule |
| sched_qid | output | 20 | Queue to schedule |
| sched_credit | output | 16 | Weight quantum given as credit |
| batch_end | output | 1 | Round closed |
| probe_qid | input | 20 | Queue id asked about by the dequeue side |
| probe_cached | output | 1 | Probed queue has a loaded line |
| probe_loading | output | 1 | Probed queue's line is being filled |

## Verification
The assertions assume that `clear` is raised only while the block waits in idle. They also assume that a read response arrives only after the read request has been accepted, and never in the same cycle. The bench clears only between requests, and its memory model answers each read two cycles after accepting it. The memory model holds `mem_req_ready` high, so every request the block raises completes in the cycle it appears. The bench runs a sweep over 24 queues, more than the 16 lines, so the least-recently-used order, write-backs, drops and activations all occur and are checked against a per-queue length model and a recency list kept in the bench.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    localparam int QID_W  = 20;
    localparam int FLEN_W = 16;
    localparam int QLEN_W = 24;
    localparam int QNT_W  = 16;
    localparam int PTR_W  = 32;
    localparam int CNT_W  = 16;

    typedef struct packed {
        logic [QLEN_W-1:0] qlen;
        logic [QLEN_W-1:0] thresh;
        logic [QNT_W-1:0]  quantum;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [CNT_W-1:0]  count;
    } qline_t;

    localparam int LINE_W = $bits(qline_t);

    typedef enum logic [1:0] {
        MOP_READ   = 2'd0,
        MOP_WRLINE = 2'd1,
        MOP_WRLEN  = 2'd2
    } mop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_ADMIT,
        ST_WRLEN,
        ST_SYNC
    } st_e;
endpackage

// File: rtl/qpc_lru_age.sv
module qpc_lru_age #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);
    // Each line keeps a distinct rank; 0 is most recent, ENTRIES-1 the oldest.
    logic [IDX_W-1:0] rank [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank[i] <= IDX_W'(i);
        end else if (clear) begin
            for (int i = 0; i < ENTRIES; i++) rank[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank[i] <= '0;
                else if (rank[i] < rank[touch_idx])
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (rank[i] == IDX_W'(ENTRIES - 1)) oldest_idx = IDX_W'(i);
    end
endmodule

// File: rtl/qpc_tag_match.sv
module qpc_tag_match #(
    parameter int ENTRIES = 16,
    parameter int QID_W = 20,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [QID_W-1:0] tags [ENTRIES],
    input  logic [ENTRIES-1:0] occ,
    input  logic [ENTRIES-1:0] loaded,
    input  logic [QID_W-1:0] look_qid,
    input  logic [QID_W-1:0] probe_qid,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             free_found,
    output logic [IDX_W-1:0] free_idx,
    output logic             probe_cached,
    output logic             probe_loading
);
    logic [ENTRIES-1:0] look_m;
    logic [ENTRIES-1:0] probe_m;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_m[g]  = occ[g] && loaded[g] && (tags[g] == look_qid);
        assign probe_m[g] = occ[g] && (tags[g] == probe_qid);
    end

    always_comb begin
        hit = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!hit && look_m[i]) begin
                hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        free_found = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_found && !occ[i]) begin
                free_found = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign probe_cached  = |(probe_m & loaded);
    assign probe_loading = |(probe_m & ~loaded);
endmodule

// File: rtl/qpc_admit.sv
module qpc_admit
    import qpc_pkg::*;
(
    input  qline_t              line_in,
    input  logic [FLEN_W-1:0]   flen,
    input  logic [PTR_W-1:0]    handle,
    output logic                admit,
    output logic                activate,
    output qline_t              line_out
);
    logic [QLEN_W:0] sum;

    always_comb begin
        sum = {1'b0, line_in.qlen} + {{(QLEN_W + 1 - FLEN_W){1'b0}}, flen};
        admit = sum <= {1'b0, line_in.thresh};
        activate = admit && (line_in.qlen == '0);
        line_out = line_in;
        if (admit) begin
            line_out.qlen  = sum[QLEN_W-1:0];
            line_out.count = line_in.count + 1'b1;
            line_out.tail  = handle;
            if (line_in.count == '0) line_out.head = handle;
        end
    end
endmodule

// File: rtl/qparam_cache.sv
module qparam_cache
    import qpc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int BATCH = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [QID_W-1:0]  req_qid,
    input  logic [PTR_W-1:0]  req_handle,
    input  logic [FLEN_W-1:0] req_len,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_op,
    output logic [QID_W-1:0]  mem_req_addr,
    output logic [LINE_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_rdata,
    output logic              drop_valid,
    output logic [PTR_W-1:0]  drop_handle,
    output logic              enq_valid,
    output logic [QID_W-1:0]  enq_qid,
    output logic [PTR_W-1:0]  enq_handle,
    output logic              sched_valid,
    output logic [QID_W-1:0]  sched_qid,
    output logic [QNT_W-1:0]  sched_credit,
    output logic              batch_end,
    input  logic [QID_W-1:0]  probe_qid,
    output logic              probe_cached,
    output logic              probe_loading
);
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int BCNT_W = $clog2(BATCH + 1);

    st_e state, next_state;

    logic [QID_W-1:0]  r_qid;
    logic [PTR_W-1:0]  r_handle;
    logic [FLEN_W-1:0] r_len;
    logic [IDX_W-1:0]  cur_idx;
    logic [BCNT_W-1:0] batch_cnt;

    logic [QID_W-1:0]   tags  [ENTRIES];
    qline_t             lines [ENTRIES];
    logic [ENTRIES-1:0] occ;
    logic [ENTRIES-1:0] loaded;

    logic             hit, free_found;
    logic [IDX_W-1:0] hit_idx, free_idx, oldest_idx;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    logic             accept, batch_full, claim;
    logic [IDX_W-1:0] claim_idx;
    logic             admit, activate;
    qline_t           cur_line, upd_line;

    assign cur_line   = lines[cur_idx];
    assign accept     = req_valid && req_ready;
    assign batch_full = (batch_cnt == BCNT_W'(BATCH));

    // A line is claimed for the new queue as the fill request begins.
    assign claim = (state == ST_LOOKUP && !hit && free_found) ||
                   (state == ST_EVICT && mem_req_ready);
    assign claim_idx = (state == ST_LOOKUP) ? free_idx : cur_idx;

    assign touch = (state == ST_LOOKUP && hit) ||
                   (state == ST_FILL_WAIT && mem_rsp_valid);
    assign touch_idx = (state == ST_LOOKUP) ? hit_idx : cur_idx;

    qpc_tag_match #(.ENTRIES(ENTRIES), .QID_W(QID_W)) u_match (
        .tags          (tags),
        .occ           (occ),
        .loaded        (loaded),
        .look_qid      (r_qid),
        .probe_qid     (probe_qid),
        .hit           (hit),
        .hit_idx       (hit_idx),
        .free_found    (free_found),
        .free_idx      (free_idx),
        .probe_cached  (probe_cached),
        .probe_loading (probe_loading)
    );

    qpc_lru_age #(.ENTRIES(ENTRIES)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .touch      (touch),
        .touch_idx  (touch_idx),
        .oldest_idx (oldest_idx)
    );

    qpc_admit u_admit (
        .line_in  (cur_line),
        .flen     (r_len),
        .handle   (r_handle),
        .admit    (admit),
        .activate (activate),
        .line_out (upd_line)
    );

    // Next-state selection.
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: begin
                if (accept)                     next_state = ST_LOOKUP;
                else if (batch_cnt != '0)       next_state = ST_SYNC;
            end
            ST_LOOKUP: begin
                if (hit)                        next_state = ST_ADMIT;
                else if (free_found)            next_state = ST_FILL_REQ;
                else                            next_state = ST_EVICT;
            end
            ST_EVICT:
                if (mem_req_ready)              next_state = ST_FILL_REQ;
            ST_FILL_REQ:
                if (mem_req_ready)              next_state = ST_FILL_WAIT;
            ST_FILL_WAIT:
                if (mem_rsp_valid)              next_state = ST_ADMIT;
            ST_ADMIT: begin
                if (admit)                      next_state = ST_WRLEN;
                else if (batch_full)            next_state = ST_SYNC;
                else                            next_state = ST_IDLE;
            end
            ST_WRLEN:
                if (mem_req_ready)              next_state = batch_full ? ST_SYNC : ST_IDLE;
            ST_SYNC:                            next_state = ST_IDLE;
            default:                            next_state = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (clear)  state <= ST_IDLE;
        else             state <= next_state;
    end

    // Request capture, round counter and current line pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_qid     <= '0;
            r_handle  <= '0;
            r_len     <= '0;
            cur_idx   <= '0;
            batch_cnt <= '0;
        end else if (clear) begin
            batch_cnt <= '0;
        end else begin
            if (accept) begin
                r_qid     <= req_qid;
                r_handle  <= req_handle;
                r_len     <= req_len;
                batch_cnt <= batch_cnt + 1'b1;
            end
            if (state == ST_LOOKUP)
                cur_idx <= hit ? hit_idx : (free_found ? free_idx : oldest_idx);
            if (state == ST_SYNC)
                batch_cnt <= '0;
        end
    end

    // Line occupancy and load flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ    <= '0;
            loaded <= '0;
        end else if (clear) begin
            occ    <= '0;
            loaded <= '0;
        end else begin
            if (claim) begin
                occ[claim_idx]    <= 1'b1;
                loaded[claim_idx] <= 1'b0;
            end
            if (state == ST_FILL_WAIT && mem_rsp_valid)
                loaded[cur_idx] <= 1'b1;
        end
    end

    // Tag and line storage.
    always_ff @(posedge clk) begin
        if (claim)
            tags[claim_idx] <= r_qid;
        if (state == ST_FILL_WAIT && mem_rsp_valid)
            lines[cur_idx] <= qline_t'(mem_rsp_rdata);
        else if (state == ST_ADMIT && admit)
            lines[cur_idx] <= upd_line;
    end

    // Outputs.
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_op    = MOP_READ;
        mem_req_addr  = r_qid;
        mem_req_wdata = cur_line;
        drop_valid    = 1'b0;
        enq_valid     = 1'b0;
        sched_valid   = 1'b0;
        batch_end     = 1'b0;
        unique case (state)
            ST_IDLE:      req_ready = !batch_full;
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_op    = MOP_WRLINE;
                mem_req_addr  = tags[cur_idx];
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_op    = MOP_READ;
                mem_req_wdata = '0;
            end
            ST_ADMIT: begin
                drop_valid  = !admit;
                enq_valid   = admit;
                sched_valid = activate;
            end
            ST_WRLEN: begin
                mem_req_valid = 1'b1;
                mem_req_op    = MOP_WRLEN;
            end
            ST_SYNC:      batch_end = 1'b1;
            default: ;
        endcase
    end

    assign drop_handle  = r_handle;
    assign enq_qid      = r_qid;
    assign enq_handle   = r_handle;
    assign sched_qid    = r_qid;
    assign sched_credit = cur_line.quantum;
endmodule

// File: rtl/qparam_cache_chk.sv
module qparam_cache_chk #(
    parameter int BATCH = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clear,
    input logic       req_valid,
    input logic       req_ready,
    input logic       mem_req_valid,
    input logic [1:0] mem_req_op,
    input logic       drop_valid,
    input logic       enq_valid,
    input logic       sched_valid,
    input logic       batch_end,
    input logic       probe_cached,
    input logic       probe_loading
);
    logic [7:0] round_acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      round_acc <= '0;
        else if (clear || batch_end)     round_acc <= '0;
        else if (req_valid && req_ready) round_acc <= round_acc + 1'b1;
    end

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_valid && enq_valid));

    assert_sched_with_enq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sched_valid |-> enq_valid);

    assert_stall_on_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == 2'd0) |-> !req_ready);

    assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!probe_cached && !probe_loading));

    assert_len_write_follows_R8: assert property (@(posedge clk) disable iff (!rst_n || clear)
        enq_valid |=> (mem_req_valid && mem_req_op == 2'd2));

    assert_round_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        round_acc <= 8'(BATCH));

    assert_no_accept_at_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
        batch_end |-> !req_ready);
endmodule

bind qparam_cache qparam_cache_chk #(.BATCH(BATCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (clear),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_op    (mem_req_op),
    .drop_valid    (drop_valid),
    .enq_valid     (enq_valid),
    .sched_valid   (sched_valid),
    .batch_end     (batch_end),
    .probe_cached  (probe_cached),
    .probe_loading (probe_loading)
);

// File: tb/qparam_cache_test.sv
module qparam_cache_test;
    localparam int CLK_PER = 20;
    localparam int ENT = 16;
    localparam int NQ = 24;

    logic          clk, rst_n, clear;
    logic          req_valid, req_ready;
    logic [19:0]   req_qid;
    logic [31:0]   req_handle;
    logic [15:0]   req_len;
    logic          mem_req_valid, mem_req_ready;
    logic [1:0]    mem_req_op;
    logic [19:0]   mem_req_addr;
    logic [143:0]  mem_req_wdata;
    logic          mem_rsp_valid;
    logic [143:0]  mem_rsp_rdata;
    logic          drop_valid, enq_valid, sched_valid, batch_end;
    logic [31:0]   drop_handle, enq_handle;
    logic [19:0]   enq_qid, sched_qid, probe_qid;
    logic [15:0]   sched_credit;
    logic          probe_cached, probe_loading;

    qparam_cache uut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .req_valid(req_valid), .req_ready(req_ready), .req_qid(req_qid),
        .req_handle(req_handle), .req_len(req_len),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata),
        .drop_valid(drop_valid), .drop_handle(drop_handle),
        .enq_valid(enq_valid), .enq_qid(enq_qid), .enq_handle(enq_handle),
        .sched_valid(sched_valid), .sched_qid(sched_qid), .sched_credit(sched_credit),
        .batch_end(batch_end), .probe_qid(probe_qid),
        .probe_cached(probe_cached), .probe_loading(probe_loading)
    );

    initial clk = 1'b0;
    always #(CLK_PER/2) clk = ~clk;

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [19:0] qid_of(input int k);
        return 20'hA0000 | 20'(k);
    endfunction
    function automatic int thr_of(input int k);
        return (k % 4 == 0) ? 0 : 200 + 50 * k;
    endfunction
    function automatic int qnt_of(input int k);
        return 100 + k;
    endfunction

    // Backing memory model, answers reads two cycles after acceptance.
    logic [143:0] bmem [32];
    int rd_cnt = 0, wl_cnt = 0, wn_cnt = 0, be_cnt = 0;
    logic [19:0] rd_addr, wl_addr, wn_addr;
    logic [143:0] wl_data, wn_data;
    time rd_time = 0, wl_time = 0;
    int rsp_cnt = 0;
    int rsp_idx = 0;

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = bmem[rsp_idx];
            end
        end
        if (batch_end) be_cnt++;
        if (mem_req_valid) begin
            case (mem_req_op)
                2'd0: begin
                    rd_cnt++; rd_addr = mem_req_addr; rd_time = $time;
                    rsp_idx = int'(mem_req_addr[4:0]); rsp_cnt = 2;
                end
                2'd1: begin
                    wl_cnt++; wl_addr = mem_req_addr; wl_data = mem_req_wdata; wl_time = $time;
                    bmem[mem_req_addr[4:0]] = mem_req_wdata;
                end
                default: begin
                    wn_cnt++; wn_addr = mem_req_addr; wn_data = mem_req_wdata;
                    bmem[mem_req_addr[4:0]][143:120] = mem_req_wdata[143:120];
                end
            endcase
        end
    end

    // Bench-side model: queue lengths and recency list (front = most recent).
    int mq [32];
    int lru [ENT];
    int lru_n = 0;

    task automatic do_req(input int k, input int len, input logic [31:0] h);
        int rd0, wl0, wn0, waited, vic, pos, newq;
        bit hit, exp_adm, exp_act, saw_load, stall_bad, done;
        bit g_drop, g_enq, g_sched;
        logic [31:0] g_h;
        logic [19:0] g_q, g_sq;
        logic [15:0] g_cr;
        rd0 = rd_cnt; wl0 = wl_cnt; wn0 = wn_cnt;
        pos = -1;
        for (int i = 0; i < lru_n; i++) if (lru[i] == k) pos = i;
        hit = (pos >= 0);
        vic = -1;
        if (hit) begin
            for (int i = pos; i > 0; i--) lru[i] = lru[i-1];
        end else begin
            if (lru_n == ENT) vic = lru[ENT-1];
            else lru_n++;
            for (int i = lru_n - 1; i > 0; i--) lru[i] = lru[i-1];
        end
        lru[0] = k;
        newq = mq[k] + len;
        exp_adm = (newq <= thr_of(k));
        exp_act = exp_adm && (mq[k] == 0);

        probe_qid = qid_of(k);
        req_qid = qid_of(k); req_handle = h; req_len = 16'(len);
        req_valid = 1'b1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        req_valid = 1'b0;

        waited = 0; saw_load = 0; stall_bad = 0; done = 0;
        g_drop = 0; g_enq = 0; g_sched = 0; g_h = '0; g_q = '0; g_sq = '0; g_cr = '0;
        while (!done && waited < 60) begin
            @(negedge clk); #1;
            waited++;
            if (rsp_cnt > 0 && probe_loading && !probe_cached) saw_load = 1;
            if (drop_valid || enq_valid) begin
                done = 1;
                g_drop = drop_valid; g_enq = enq_valid; g_sched = sched_valid;
                g_h = drop_valid ? drop_handle : enq_handle;
                g_q = enq_qid; g_sq = sched_qid; g_cr = sched_credit;
            end else if (req_ready) stall_bad = 1;
        end

        chk(done, "R6", "outcome seen", done, 1);
        if (exp_adm) begin
            chk(g_enq && !g_drop, "R6", "admit", g_enq, 1);
            chk(g_q == qid_of(k) && g_h == h, "R6", "enq qid/handle", g_h, h);
            chk(g_sched == exp_act, "R7", "sched pulse", g_sched, exp_act);
            if (exp_act)
                chk(g_sq == qid_of(k) && g_cr == 16'(qnt_of(k)), "R7", "sched credit", g_cr, qnt_of(k));
        end else begin
            chk(g_drop && !g_enq && !g_sched, "R5", "drop", g_drop, 1);
            chk(g_h == h, "R5", "drop handle", g_h, h);
        end
        if (hit) begin
            chk(waited == 2, "R2", "hit latency", waited, 2);
            chk(rd_cnt == rd0 && wl_cnt == wl0, "R2", "hit mem traffic", rd_cnt - rd0, 0);
        end else begin
            chk(rd_cnt == rd0 + 1 && rd_addr == qid_of(k), "R3", "fill read", rd_addr, qid_of(k));
            chk(!stall_bad, "R3", "input stalled", stall_bad, 0);
            chk(saw_load, "R9", "probe loading", saw_load, 1);
            chk(probe_cached, "R9", "probe cached after fill", probe_cached, 1);
            if (vic >= 0) begin
                chk(wl_cnt == wl0 + 1 && wl_addr == qid_of(vic), "R4", "LRU write-back", wl_addr, qid_of(vic));
                chk(wl_time < rd_time, "R4", "write-back before read", wl_time, rd_time);
                chk(int'(wl_data[143:120]) == mq[vic], "R11", "evicted length", wl_data[143:120], mq[vic]);
            end else begin
                chk(wl_cnt == wl0, "R4", "no write-back with free line", wl_cnt - wl0, 0);
            end
        end

        @(negedge clk); #1;
        if (exp_adm) begin
            chk(wn_cnt == wn0 + 1 && wn_addr == qid_of(k), "R8", "length write", wn_cnt - wn0, 1);
            chk(int'(wn_data[143:120]) == newq, "R8", "length value", wn_data[143:120], newq);
            mq[k] = newq;
        end else begin
            chk(wn_cnt == wn0, "R5", "no length write on drop", wn_cnt - wn0, 0);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        failures++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int b0;
        rst_n = 1'b0; clear = 1'b0; req_valid = 1'b0;
        req_qid = '0; req_handle = '0; req_len = '0;
        mem_req_ready = 1'b1; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
        probe_qid = qid_of(3);
        for (int k = 0; k < 32; k++) begin
            mq[k] = 0;
            bmem[k] = {24'd0, 24'(thr_of(k)), 16'(qnt_of(k)), 32'd0, 32'd0, 16'd0};
        end
        repeat (3) @(negedge clk);
        #1;
        chk(!probe_cached && !probe_loading, "R1", "reset probe", probe_cached, 0);
        chk(!mem_req_valid && !drop_valid && !enq_valid && !batch_end, "R1", "reset outputs quiet", mem_req_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready, "R1", "ready after reset", req_ready, 1);

        // Directed: one queue through activation, hit and threshold drop.
        do_req(1, 100, 32'h1111_0001);
        do_req(1, 100, 32'h1111_0002);
        do_req(1, 100, 32'h1111_0003);
        do_req(4, 10, 32'h4444_0001);

        // Sweep over more queues than lines, mixing hits, evictions and drops.
        for (int r = 0; r < 4; r++)
            for (int j = 0; j < NQ; j++) begin
                int k;
                k = (j * 7 + r * 3) % NQ;
                do_req(k, 40 + (k * 13 + r * 29 + j) % 90, 32'(r * 1000 + j));
            end
        for (int j = 0; j < 8; j++) do_req(j % 3, 45, 32'h2000 + 32'(j));

        probe_qid = 20'hFFFFF;
        @(negedge clk); #1;
        chk(!probe_cached && !probe_loading, "R9", "unknown queue probe", probe_cached, 0);

        // Invalidate everything.
        probe_qid = qid_of(lru[0]);
        clear = 1'b1;
        @(negedge clk); #1;
        clear = 1'b0;
        chk(!probe_cached && !probe_loading, "R1", "clear empties", probe_cached, 0);
        lru_n = 0;
        do_req(lru[0], 20, 32'h5555_0001);

        // Rounds: seven back-to-back requests make two rounds.
        repeat (4) @(negedge clk);
        #1;
        b0 = be_cnt;
        for (int j = 0; j < 7; j++) do_req(2 + 4 * (j % 2), 5, 32'h6000 + 32'(j));
        repeat (4) @(negedge clk);
        #1;
        chk(be_cnt - b0 == 2, "R10", "round count", be_cnt - b0, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule